// File: doc/BRIEF.md
# Disk Task-File Register Decoder

This block is the host-facing register window of an embedded disk device attached to a 40-pin AT-style parallel bus. The host reaches it through two active-low chip selects, one for the command group and one for the control group, a 3-bit register address, and active-low read and write strobes. The block decodes these lines and holds the parameter registers the host loads before a command. It latches the command code and hands it to the device-side controller as a one-cycle request. It also drives read data back onto the low byte of the bus, with a per-line drive enable.

One address can name different registers for reads and for writes. While a command runs, the busy flag hides the whole command group: every read there returns the status byte. The device-side controller supplies the live status flags, the drive-address byte and a completion event that carries a pass/fail result and an error code. In return it receives the parameter register contents, the command request, and the soft-reset and DMA-enable controls. All bus inputs are treated as synchronous to `clk`. A write takes effect on the clock edge that first sees the write strobe high again.

Top module: `disk_taskfile_regs`

## Requirements
- R1: After reset the six parameter outputs, soft_reset, dma_en, cmd_valid and bad_sel are 0, the error register reads 8'h01, and status bits BSY (bit 7) and ERR (bit 0) are 0.
- R2: With only the command select low, the register is written at the rising edge of wr_n, not while wr_n is low. The addresses are: 1 precomp, 2 sec_count, 3 sec_num, 4 cyl_lo, 5 cyl_hi, 6 drv_head. A write to address 0 changes nothing.
- R3: With only the command select low, rd_n low and BSY clear, the read map is as follows. Address 1 returns the error register. Addresses 2 to 6 return the register written at that address. Address 7 returns status = {BSY, dev_flags[5:0], ERR}. Each of these reads has rdata_oe = 8'hFF. Address 0 drives nothing (rdata_oe = 0).
- R4: A write of a nonzero code to command address 7 sets BSY and clears ERR. In the cycle after the edge that takes the write, cmd_valid is high for one cycle and cmd_code holds the written code.
- R5: While BSY is set, a read of any command-group address (0 to 7) returns the status byte with rdata_oe = 8'hFF.
- R6: A write of code 8'h00 to command address 7 gives no cmd_valid and leaves BSY unchanged. It sets ERR, and the error register becomes 8'h04 (abort, bit 2).
- R7: dev_done while BSY is set clears BSY and copies dev_fail into ERR. On a failure, dev_err_code is also loaded into the error register. dev_done while BSY is clear has no effect. A command write in the same cycle as dev_done takes precedence.
- R8: With only the control select low and rd_n low, address 6 returns the status byte whatever the state of BSY (rdata_oe = 8'hFF). Address 7 returns {1'b0, dev_drv_addr} with bit 7 undriven (rdata_oe = 8'h7F). Other control addresses drive nothing.
- R9: A control-group write to address 6 sets soft_reset from data bit 2 and dma_en from data bit 0, ignoring the other bits. A control write to address 7 changes nothing.
- R10: While BSY is set, writes to command addresses 1 to 6 are ignored.
- R11: A write with both selects high or both low pulses bad_sel for one cycle, in the cycle after the edge that takes the write, and changes nothing. A read with such a select drives nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_cmd_n | input | 1 | Command group select, active low |
| cs_ctl_n | input | 1 | Control group select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Host write data, low byte |
| rdata | output | 8 | Read data, low byte |
| rdata_oe | output | 8 | Per-line drive enable for rdata |
| dev_flags | input | 6 | Device status flags, status bits 6..1 |
| dev_drv_addr | input | 7 | Drive-address byte, bits 6..0 |
| dev_done | input | 1 | Command completion event |
| dev_fail | input | 1 | Completion result: 1 = error |
| dev_err_code | input | 8 | Error code reported on failure |
| cmd_valid | output | 1 | One-cycle new-command request |
| cmd_code | output | 8 | Last accepted command code |
| precomp | output | 8 | Write precompensation register |
| sec_count | output | 8 | Sector count register |
| sec_num | output | 8 | Sector number register |
| cyl_lo | output | 8 | Cylinder low register |
| cyl_hi | output | 8 | Cylinder high register |
| drv_head | output | 8 | Drive/head register |
| soft_reset | output | 1 | Soft reset control |
| dma_en | output | 1 | DMA enable control |
| bad_sel | output | 1 | Pulse on a write with an invalid select |

## Verification
The hardest situation to reach is a command write that lands in the same clock as the device's completion event while the block is already busy. The block must also ignore parameter writes made at that moment. The stimulus gets there by starting a command, holding dev_done high across the cycle in which the next command's strobe rises, and then reading the command group. The read must still be shadowed, because the new command keeps BSY set. A behavioural model compares every output and every read on each clock, so the shadow, the swapped read/write maps and the undriven bit 7 are checked on each access.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int TF_DW      = 8;
  localparam int TF_AW      = 3;
  localparam int TF_FLAGS_W = TF_DW - 2;
  localparam int BSY_BIT    = TF_DW - 1;
  localparam int ERR_BIT    = 0;
  localparam int SRST_BIT   = 2;
  localparam int DMAEN_BIT  = 0;
  localparam logic [TF_DW-1:0] CMD_RSVD   = '0;
  localparam logic [TF_DW-1:0] ABORT_CODE = TF_DW'(1) << 2;
  localparam logic [TF_DW-1:0] ERR_INIT   = TF_DW'(1);
  localparam logic [TF_DW-1:0] CTL_MASK   = (TF_DW'(1) << SRST_BIT) | (TF_DW'(1) << DMAEN_BIT);

  typedef enum logic [3:0] {
    W_NONE, W_BAD, W_DATA, W_PRECOMP, W_SCOUNT, W_SNUM,
    W_CYLLO, W_CYLHI, W_DRVHD, W_CMD, W_DEVCTL
  } tf_wsel_e;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_ERROR, RD_SCOUNT, RD_SNUM, RD_CYLLO,
    RD_CYLHI, RD_DRVHD, RD_STATUS, RD_ALTSTAT, RD_DRVADDR
  } tf_rsel_e;

  typedef struct packed {
    logic [TF_DW-1:0] precomp;
    logic [TF_DW-1:0] scount;
    logic [TF_DW-1:0] snum;
    logic [TF_DW-1:0] cyllo;
    logic [TF_DW-1:0] cylhi;
    logic [TF_DW-1:0] drvhd;
  } tf_file_t;
endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
  import tf_pkg::*;
(
  input  logic             cs_cmd_n,
  input  logic             cs_ctl_n,
  input  logic [TF_AW-1:0] addr,
  output tf_wsel_e         wsel,
  output tf_rsel_e         rsel
);
  logic cmd_grp, ctl_grp;
  assign cmd_grp = !cs_cmd_n && cs_ctl_n;
  assign ctl_grp = cs_cmd_n && !cs_ctl_n;

  always_comb begin
    wsel = W_NONE;
    rsel = RD_NONE;
    if (cmd_grp) begin
      unique case (addr)
        3'd0: begin wsel = W_DATA;    rsel = RD_DATA;   end
        3'd1: begin wsel = W_PRECOMP; rsel = RD_ERROR;  end
        3'd2: begin wsel = W_SCOUNT;  rsel = RD_SCOUNT; end
        3'd3: begin wsel = W_SNUM;    rsel = RD_SNUM;   end
        3'd4: begin wsel = W_CYLLO;   rsel = RD_CYLLO;  end
        3'd5: begin wsel = W_CYLHI;   rsel = RD_CYLHI;  end
        3'd6: begin wsel = W_DRVHD;   rsel = RD_DRVHD;  end
        default: begin wsel = W_CMD;  rsel = RD_STATUS; end
      endcase
    end else if (ctl_grp) begin
      if (addr == 3'd6) begin
        wsel = W_DEVCTL;
        rsel = RD_ALTSTAT;
      end else if (addr == 3'd7) begin
        rsel = RD_DRVADDR;
      end
    end else begin
      wsel = W_BAD;
    end
  end
endmodule

// File: rtl/tf_regs.sv
module tf_regs
  import tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ev,
  input  tf_wsel_e         wsel,
  input  logic [TF_DW-1:0] wdata,
  input  logic             dev_done,
  input  logic             dev_fail,
  input  logic [TF_DW-1:0] dev_err_code,
  output tf_file_t         file_q,
  output logic             busy_q,
  output logic             err_q,
  output logic [TF_DW-1:0] ecode_q,
  output logic             cmdv_q,
  output logic [TF_DW-1:0] code_q,
  output logic [TF_DW-1:0] ctl_q,
  output logic             bad_q
);
  tf_file_t         file_d;
  logic             busy_d, err_d, cmdv_d, bad_d;
  logic [TF_DW-1:0] ecode_d, code_d, ctl_d;

  always_comb begin
    file_d  = file_q;
    busy_d  = busy_q;
    err_d   = err_q;
    ecode_d = ecode_q;
    code_d  = code_q;
    ctl_d   = ctl_q;
    cmdv_d  = 1'b0;
    bad_d   = 1'b0;
    if (dev_done && busy_q) begin
      busy_d = 1'b0;
      err_d  = dev_fail;
      if (dev_fail) ecode_d = dev_err_code;
    end
    if (wr_ev) begin
      unique case (wsel)
        W_BAD: bad_d = 1'b1;
        W_CMD: begin
          if (wdata == CMD_RSVD) begin
            err_d   = 1'b1;
            ecode_d = ABORT_CODE;
          end else begin
            busy_d = 1'b1;
            err_d  = 1'b0;
            cmdv_d = 1'b1;
            code_d = wdata;
          end
        end
        W_DEVCTL:  ctl_d = wdata & CTL_MASK;
        W_PRECOMP: if (!busy_q) file_d.precomp = wdata;
        W_SCOUNT:  if (!busy_q) file_d.scount  = wdata;
        W_SNUM:    if (!busy_q) file_d.snum    = wdata;
        W_CYLLO:   if (!busy_q) file_d.cyllo   = wdata;
        W_CYLHI:   if (!busy_q) file_d.cylhi   = wdata;
        W_DRVHD:   if (!busy_q) file_d.drvhd   = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      file_q  <= '0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      ecode_q <= ERR_INIT;
      code_q  <= '0;
      ctl_q   <= '0;
      cmdv_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      file_q  <= file_d;
      busy_q  <= busy_d;
      err_q   <= err_d;
      ecode_q <= ecode_d;
      code_q  <= code_d;
      ctl_q   <= ctl_d;
      cmdv_q  <= cmdv_d;
      bad_q   <= bad_d;
    end
  end
endmodule

// File: rtl/tf_rdmux.sv
module tf_rdmux
  import tf_pkg::*;
(
  input  logic              rd_n,
  input  tf_rsel_e          rsel,
  input  logic              busy,
  input  logic [TF_DW-1:0]  status,
  input  logic [TF_DW-1:0]  ecode,
  input  tf_file_t          file,
  input  logic [TF_DW-2:0]  drv_addr,
  output logic [TF_DW-1:0]  rdata,
  output logic [TF_DW-1:0]  rdata_oe
);
  logic cmd_rsel;
  assign cmd_rsel = (rsel != RD_NONE) && (rsel != RD_ALTSTAT) && (rsel != RD_DRVADDR);

  always_comb begin
    rdata    = '0;
    rdata_oe = '0;
    if (!rd_n) begin
      if (busy && cmd_rsel) begin
        rdata    = status;
        rdata_oe = '1;
      end else begin
        rdata_oe = '1;
        unique case (rsel)
          RD_ERROR:   rdata = ecode;
          RD_SCOUNT:  rdata = file.scount;
          RD_SNUM:    rdata = file.snum;
          RD_CYLLO:   rdata = file.cyllo;
          RD_CYLHI:   rdata = file.cylhi;
          RD_DRVHD:   rdata = file.drvhd;
          RD_STATUS,
          RD_ALTSTAT: rdata = status;
          RD_DRVADDR: begin
            rdata    = {1'b0, drv_addr};
            rdata_oe = {1'b0, {(TF_DW-1){1'b1}}};
          end
          default:    rdata_oe = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/disk_taskfile_regs.sv
module disk_taskfile_regs
  import tf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_cmd_n,
  input  logic                  cs_ctl_n,
  input  logic [TF_AW-1:0]      addr,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [TF_DW-1:0]      wdata,
  output logic [TF_DW-1:0]      rdata,
  output logic [TF_DW-1:0]      rdata_oe,
  input  logic [TF_FLAGS_W-1:0] dev_flags,
  input  logic [TF_DW-2:0]      dev_drv_addr,
  input  logic                  dev_done,
  input  logic                  dev_fail,
  input  logic [TF_DW-1:0]      dev_err_code,
  output logic                  cmd_valid,
  output logic [TF_DW-1:0]      cmd_code,
  output logic [TF_DW-1:0]      precomp,
  output logic [TF_DW-1:0]      sec_count,
  output logic [TF_DW-1:0]      sec_num,
  output logic [TF_DW-1:0]      cyl_lo,
  output logic [TF_DW-1:0]      cyl_hi,
  output logic [TF_DW-1:0]      drv_head,
  output logic                  soft_reset,
  output logic                  dma_en,
  output logic                  bad_sel
);
  logic             wr_n_q, wr_rise;
  tf_wsel_e         wsel;
  tf_rsel_e         rsel;
  tf_file_t         file_q;
  logic             busy_q, err_q;
  logic [TF_DW-1:0] ecode_q, ctl_q, status_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_n_q <= 1'b1;
    else        wr_n_q <= wr_n;
  end
  assign wr_rise = wr_n && !wr_n_q;

  tf_addr_decode i_dec (
    .cs_cmd_n (cs_cmd_n), .cs_ctl_n (cs_ctl_n), .addr (addr),
    .wsel (wsel), .rsel (rsel)
  );

  tf_regs i_regs (
    .clk (clk), .rst_n (rst_n), .wr_ev (wr_rise), .wsel (wsel), .wdata (wdata),
    .dev_done (dev_done), .dev_fail (dev_fail), .dev_err_code (dev_err_code),
    .file_q (file_q), .busy_q (busy_q), .err_q (err_q), .ecode_q (ecode_q),
    .cmdv_q (cmd_valid), .code_q (cmd_code), .ctl_q (ctl_q), .bad_q (bad_sel)
  );

  assign status_w = {busy_q, dev_flags, err_q};

  tf_rdmux i_rdmux (
    .rd_n (rd_n), .rsel (rsel), .busy (busy_q), .status (status_w),
    .ecode (ecode_q), .file (file_q), .drv_addr (dev_drv_addr),
    .rdata (rdata), .rdata_oe (rdata_oe)
  );

  assign precomp    = file_q.precomp;
  assign sec_count  = file_q.scount;
  assign sec_num    = file_q.snum;
  assign cyl_lo     = file_q.cyllo;
  assign cyl_hi     = file_q.cylhi;
  assign drv_head   = file_q.drvhd;
  assign soft_reset = ctl_q[SRST_BIT];
  assign dma_en     = ctl_q[DMAEN_BIT];
endmodule

// File: rtl/tf_checker.sv
module tf_checker
  import tf_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cs_cmd_n,
  input logic             cs_ctl_n,
  input logic [TF_AW-1:0] addr,
  input logic             rd_n,
  input logic             wr_rise,
  input logic [TF_DW-1:0] wdata,
  input logic             busy_q,
  input logic             err_q,
  input logic [TF_DW-1:0] status_w,
  input logic [TF_DW-1:0] rdata,
  input logic [TF_DW-1:0] rdata_oe,
  input logic             cmd_valid,
  input logic [TF_DW-1:0] cmd_code,
  input logic [TF_DW-1:0] sec_count,
  input logic [TF_DW-1:0] drv_head,
  input logic             bad_sel
);
  logic cmd_only, ctl_only;
  assign cmd_only = !cs_cmd_n && cs_ctl_n;
  assign ctl_only = cs_cmd_n && !cs_ctl_n;

  a_r4_cmd_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && cmd_only && addr == 3'd7 && wdata != '0)
      |=> (busy_q && !err_q && cmd_valid && cmd_code == $past(wdata)));

  a_r6_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && cmd_only && addr == 3'd7 && wdata == '0) |=> (!cmd_valid && err_q));

  a_r5_busy_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && busy_q && cmd_only) |-> (rdata == status_w && rdata_oe == '1));

  a_r8_bit7_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && ctl_only && addr == 3'd7) |-> (rdata_oe[TF_DW-1] == 1'b0));

  a_r11_bad_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sel |-> ($stable(sec_count) && $stable(drv_head) && !cmd_valid));

  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && busy_q && cmd_only && addr == 3'd2) |=> $stable(sec_count));

  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
endmodule

bind disk_taskfile_regs tf_checker i_tf_checker (
  .clk (clk), .rst_n (rst_n), .cs_cmd_n (cs_cmd_n), .cs_ctl_n (cs_ctl_n),
  .addr (addr), .rd_n (rd_n), .wr_rise (wr_rise), .wdata (wdata),
  .busy_q (busy_q), .err_q (err_q), .status_w (status_w), .rdata (rdata),
  .rdata_oe (rdata_oe), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
  .sec_count (sec_count), .drv_head (drv_head), .bad_sel (bad_sel)
);

// File: tb/test_disk_taskfile_regs.sv
module test_disk_taskfile_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_cmd_n = 1'b1, cs_ctl_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [5:0] dev_flags = 6'h15;
  logic [6:0] dev_drv_addr = 7'h5A;
  logic       dev_done = 1'b0, dev_fail = 1'b0;
  logic [7:0] dev_err_code = '0;
  logic [7:0] rdata, rdata_oe, cmd_code, precomp, sec_count, sec_num, cyl_lo, cyl_hi, drv_head;
  logic       cmd_valid, soft_reset, dma_en, bad_sel;

  disk_taskfile_regs i_disk_taskfile_regs (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  // reference model state
  int m_file[1:6];
  int m_busy, m_err, m_ecode, m_cmdv, m_code, m_srst, m_dma, m_bad;
  bit m_prev_wr = 1'b1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 6; i++) m_file[i] = 0;
      m_busy = 0; m_err = 0; m_ecode = 1; m_cmdv = 0; m_code = 0;
      m_srst = 0; m_dma = 0; m_bad = 0; m_prev_wr = 1'b1;
    end else begin
      bit rise;
      int busy_old;
      rise = wr_n && !m_prev_wr;
      m_prev_wr = wr_n;
      busy_old = m_busy;
      m_cmdv = 0; m_bad = 0;
      if (dev_done && busy_old != 0) begin
        m_busy = 0; m_err = dev_fail;
        if (dev_fail) m_ecode = dev_err_code;
      end
      if (rise) begin
        if (cs_cmd_n == cs_ctl_n) m_bad = 1;
        else if (!cs_cmd_n) begin
          if (addr == 7) begin
            if (wdata == 0) begin m_err = 1; m_ecode = 8'h04; end
            else begin m_busy = 1; m_err = 0; m_cmdv = 1; m_code = wdata; end
          end else if (addr != 0 && busy_old == 0) m_file[addr] = wdata;
        end else if (addr == 6) begin
          m_srst = wdata[2]; m_dma = wdata[0];
        end
      end
    end
  end

  function automatic int m_status();
    return (m_busy << 7) | (int'(dev_flags) << 1) | m_err;
  endfunction

  // compare every clock, 2 ns before the rising edge
  always @(negedge clk) begin
    #8;
    cycles++;
    if (!rst_n) begin
      check(sec_count == 0 && drv_head == 0 && precomp == 0, "R1", "params", sec_count, 0);
      check(cmd_valid == 0 && bad_sel == 0 && soft_reset == 0 && dma_en == 0, "R1", "ctl outs",
            {cmd_valid, bad_sel, soft_reset, dma_en}, 0);
    end else begin
      int exp_d, exp_oe;
      string tag;
      check(precomp == m_file[1] && sec_count == m_file[2] && sec_num == m_file[3] &&
            cyl_lo == m_file[4] && cyl_hi == m_file[5] && drv_head == m_file[6],
            m_busy ? "R2 R10" : "R2", "param regs", {precomp, sec_count, sec_num, cyl_lo, cyl_hi, drv_head},
            (m_file[1] << 40) | (m_file[2] << 32) | (m_file[3] << 24) | (m_file[4] << 16) | (m_file[5] << 8) | m_file[6]);
      check(cmd_valid == m_cmdv && (m_cmdv == 0 || cmd_code == m_code), "R4 R6", "cmd_valid/code",
            {cmd_valid, cmd_code}, (m_cmdv << 8) | m_code);
      check(soft_reset == m_srst && dma_en == m_dma, "R9", "srst/dma", {soft_reset, dma_en}, (m_srst << 1) | m_dma);
      check(bad_sel == m_bad, "R11", "bad_sel", bad_sel, m_bad);
      exp_d = 0; exp_oe = 0; tag = "R11";
      if (!rd_n) begin
        if (!cs_cmd_n && cs_ctl_n) begin
          if (m_busy != 0) begin exp_d = m_status(); exp_oe = 8'hFF; tag = "R5 R7"; end
          else begin
            tag = "R3 R7";
            exp_oe = (addr == 0) ? 0 : 8'hFF;
            if (addr == 1) exp_d = m_ecode;
            else if (addr == 7) exp_d = m_status();
            else if (addr != 0) exp_d = m_file[addr];
          end
        end else if (cs_cmd_n && !cs_ctl_n) begin
          tag = "R8";
          if (addr == 6) begin exp_d = m_status(); exp_oe = 8'hFF; end
          else if (addr == 7) begin exp_d = dev_drv_addr; exp_oe = 8'h7F; end
        end
      end
      check(rdata == exp_d[7:0] && rdata_oe == exp_oe[7:0], tag, "read",
            {rdata_oe, rdata}, (exp_oe << 8) | exp_d);
    end
  end

  always @(posedge clk) if (cycles > 20000) begin
    errors++;
    $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
    finish_run();
  end

  task automatic wr(input bit cmd, input bit ctl, input int a, input int d);
    @(negedge clk);
    cs_cmd_n = ~cmd; cs_ctl_n = ~ctl; addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_cmd_n = 1'b1; cs_ctl_n = 1'b1; wdata = '0;
  endtask

  task automatic rd(input bit cmd, input bit ctl, input int a);
    @(negedge clk);
    cs_cmd_n = ~cmd; cs_ctl_n = ~ctl; addr = a; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
  endtask

  task automatic done(input bit fail, input int code);
    @(negedge clk); dev_done = 1'b1; dev_fail = fail; dev_err_code = code;
    @(negedge clk); dev_done = 1'b0; dev_fail = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1, 0, 1);                          // R1 error reg reads 01
    rd(1, 0, 7);
    for (int a = 1; a <= 6; a++) wr(1, 0, a, 8'h10 + a * 8'h11);   // R2
    for (int a = 0; a <= 7; a++) rd(1, 0, a);                       // R3
    wr(1, 0, 0, 8'hEE);                   // data port write: no change
    done(0, 0);                           // R7 done when idle ignored
    rd(1, 0, 7);
    wr(1, 0, 7, 8'h20);                   // R4 command starts
    for (int a = 0; a <= 7; a++) rd(1, 0, a);                       // R5 shadow
    rd(0, 1, 6); rd(0, 1, 7);             // R8 control reads while busy
    wr(1, 0, 2, 8'h99);                   // R10 ignored while busy
    wr(1, 0, 6, 8'hA5);
    wr(0, 1, 6, 8'hFF);                   // R9 allowed while busy
    done(1, 8'h40);                       // R7 failure
    rd(1, 0, 1); rd(1, 0, 7); rd(1, 0, 2);
    wr(1, 0, 7, 8'h30);                   // clears ERR
    // R7 corner: next command strobe rises while dev_done is high
    @(negedge clk);
    cs_cmd_n = 1'b0; cs_ctl_n = 1'b1; addr = 3'd7; wdata = 8'h31; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; dev_done = 1'b1;
    @(negedge clk); dev_done = 1'b0; cs_cmd_n = 1'b1;
    rd(1, 0, 3);
    done(0, 0);
    wr(1, 0, 7, 8'h00);                   // R6 reserved code
    rd(1, 0, 1); rd(1, 0, 7);
    wr(0, 1, 6, 8'hFB);                   // R9 bits other than 2/0 ignored
    wr(0, 1, 7, 8'h05);                   // control addr 7 write ignored
    wr(0, 0, 2, 8'h77);                   // R11 no select
    wr(1, 1, 3, 8'h66);                   // R11 both selects
    rd(1, 1, 2); rd(0, 0, 7); rd(0, 1, 3);
    dev_flags = 6'h2A; dev_drv_addr = 7'h7F;
    rd(1, 0, 7); rd(0, 1, 7);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule